// File: doc/BRIEF.md
# Descriptor-Driven Crypto Channel

This block sequences one channel of a crypto accelerator. Software writes a descriptor address into the channel's fetch register, and that single write is enough to start the work. The channel then reads the descriptor from system memory through a bus-master read port and decodes the header operation code. From that code it asks a controller for an execution unit of the matching type. Once the unit is granted, the channel walks the descriptor's length/pointer items in order, reads each item word by word, and streams the words to the unit with a tag that names the item. It then collects the unit's output words, writes them back to memory, and hands the unit back to the controller.

Every descriptor ends with a pointer to the next one, so one fetch-register write can run a chain of operations with no further help from the host. Flow control works one word at a time: each read word is held until the unit accepts it. Because of this, items far larger than the unit's 512-byte buffer pass through without any special handling. The cipher engines, the bus protocol and the arbitration between channels are outside this block. They appear only as request/grant and valid/ready ports.

Top module: `cc_channel`

## Requirements
- R1: A `fetch_wr` pulse while the channel is idle starts an operation. On the next cycle `busy` is 1 and a read request for the written address is presented. A `fetch_wr` pulse while `busy` is 1 is ignored.
- R2: A descriptor is six 64-bit words, read in order from addresses base+8*i. Word 0 carries the operation code in bits 63:56. Words 1 to 4 each hold a byte length in bits 63:32 and an address in bits 31:0, for context, key, input data and output, in that order. Word 5 holds the next-descriptor address in bits 31:0.
- R3: Operation codes 0x11, 0x22, 0x33 and 0x44 select unit types 1, 2, 3 and 4 on `eu_type`. `eu_req` stays high until `eu_grant`. No item word reaches the unit and nothing is written to memory before the grant.
- R4: Context, key and input data are moved in that order. An item of length L is read as ceil(L/8) words from ptr+8*k. Each word is delivered on `eu_in_data` with `eu_in_kind` equal to 0 for context, 1 for key and 2 for data.
- R5: An item or output whose length is zero is skipped, with no memory access and no unit transfer.
- R6: The channel keeps at most one read outstanding and holds each word on the unit input until `eu_in_ready`. Items longer than 512 bytes therefore stream completely.
- R7: The output is ceil(L/8) words taken from `eu_out_data` in arrival order and written to out_ptr+8*k.
- R8: `eu_release` is a one-cycle pulse that follows the last output write of a descriptor. It comes before any read of the next descriptor.
- R9: A nonzero next pointer fetches the next descriptor at that address. A zero next pointer ends the chain.
- R10: At the end of a chain, `done` pulses for exactly one cycle and `status_done` becomes 1. `status_done` stays 1 until the next accepted fetch write clears it.
- R11: An operation code not listed in R3 sets `status_err` and returns the channel to idle, with no unit request and no `done`. The next accepted fetch write clears `status_err`.
- R12: A read or write request that is not accepted keeps its valid, address and data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_wr | input | 1 | Write strobe of the fetch register |
| fetch_addr | input | 32 | Descriptor address written to the fetch register |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Read data word |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | 32 | Write byte address |
| wr_req_data | output | 64 | Write data word |
| eu_req | output | 1 | Execution unit request |
| eu_type | output | 3 | Requested unit type |
| eu_grant | input | 1 | Unit granted |
| eu_release | output | 1 | Unit handed back |
| eu_in_valid | output | 1 | Word offered to the unit |
| eu_in_ready | input | 1 | Unit accepts the word |
| eu_in_data | output | 64 | Word for the unit |
| eu_in_kind | output | 2 | Item tag: 0 context, 1 key, 2 data |
| eu_out_valid | input | 1 | Unit output word valid |
| eu_out_ready | output | 1 | Channel takes the output word |
| eu_out_data | input | 64 | Unit output word |
| busy | output | 1 | Channel is working |
| done | output | 1 | One-cycle chain-complete pulse |
| status_done | output | 1 | Sticky chain-complete bit |
| status_err | output | 1 | Sticky unknown-operation bit |

## Verification
The assertions check the cycle-level handshake rules on every cycle:
- stable read, write and unit-input requests while they wait;
- a held unit request;
- no unit input or memory write outside a grant;
- single-cycle release and done pulses;
- the start of a descriptor read after an idle fetch write;
- a quiet channel after an error.

Only the bench's scenarios can show the order and content of the traffic. This covers the descriptor walk, item order and tags, word counts for odd byte lengths, skipped zero-length items, output addresses and data, chaining across three descriptors, a fetch write ignored mid-run, and error recovery.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int WORD_W     = 64;
    localparam int PTR_W      = 32;
    localparam int LEN_W      = 32;
    localparam int OP_W       = 8;
    localparam int UNIT_W     = 3;
    localparam int DESC_WORDS = 6;
    localparam int ITEMS_IN   = 3;
    localparam int CNT_W      = LEN_W - 2;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        ITEM_CTX  = 2'd0,
        ITEM_KEY  = 2'd1,
        ITEM_DATA = 2'd2
    } item_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } span_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        span_t            ctx;
        span_t            key;
        span_t            din;
        span_t            dout;
        logic [PTR_W-1:0] next;
    } job_t;

    typedef struct packed {
        logic              known;
        logic [UNIT_W-1:0] unit;
    } route_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DREQ,
        S_DWAIT,
        S_DECODE,
        S_ALLOC,
        S_PSEL,
        S_IREQ,
        S_IWAIT,
        S_IPUSH,
        S_OSEL,
        S_OPULL,
        S_OWR,
        S_REL,
        S_FIN
    } state_e;

    function automatic route_t route_op(input logic [OP_W-1:0] op);
        route_t r;
        r.known = 1'b1;
        case (op)
            8'h11:   r.unit = UNIT_W'(1);
            8'h22:   r.unit = UNIT_W'(2);
            8'h33:   r.unit = UNIT_W'(3);
            8'h44:   r.unit = UNIT_W'(4);
            default: begin
                r.known = 1'b0;
                r.unit  = '0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] word_count(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] s;
        s = {1'b0, len} + (LEN_W+1)'(WORD_BYTES - 1);
        return s[LEN_W:3];
    endfunction

endpackage

// File: rtl/cc_job_store.sv
module cc_job_store
    import cc_pkg::*;
#(
    parameter int WORDS = DESC_WORDS,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output job_t              job
);

    job_t job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
        end else if (cap) begin
            case (idx)
                IDX_W'(0): job_q.op   <= word[WORD_W-1 -: OP_W];
                IDX_W'(1): job_q.ctx  <= word;
                IDX_W'(2): job_q.key  <= word;
                IDX_W'(3): job_q.din  <= word;
                IDX_W'(4): job_q.dout <= word;
                IDX_W'(5): job_q.next <= word[PTR_W-1:0];
                default:   ;
            endcase
        end
    end

    assign job = job_q;

endmodule

// File: rtl/cc_xfer_ctr.sv
module cc_xfer_ctr
    import cc_pkg::*;
#(
    parameter int AW   = PTR_W,
    parameter int CW   = CNT_W,
    parameter int STEP = WORD_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_words,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_words;
        end else if (step) begin
            addr_q <= addr_q + AW'(STEP);
            rem_q  <= rem_q - CW'(1);
        end
    end

    assign addr = addr_q;
    assign last = (rem_q == CW'(1));

endmodule

// File: rtl/cc_flags.sv
module cc_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_done,
    input  logic set_err,
    output logic done_flag,
    output logic err_flag
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (set_done) done_flag <= 1'b1;
            if (set_err)  err_flag  <= 1'b1;
        end
    end

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int ADDR_W = PTR_W,
    parameter int DATA_W = WORD_W,
    parameter int TYPE_W = UNIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_wr,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              wr_req_valid,
    input  logic              wr_req_ready,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [DATA_W-1:0] wr_req_data,
    output logic              eu_req,
    output logic [TYPE_W-1:0] eu_type,
    input  logic              eu_grant,
    output logic              eu_release,
    output logic              eu_in_valid,
    input  logic              eu_in_ready,
    output logic [DATA_W-1:0] eu_in_data,
    output logic [1:0]        eu_in_kind,
    input  logic              eu_out_valid,
    output logic              eu_out_ready,
    input  logic [DATA_W-1:0] eu_out_data,
    output logic              busy,
    output logic              done,
    output logic              status_done,
    output logic              status_err
);

    localparam int IDX_W  = $clog2(DESC_WORDS);
    localparam int LAST_W = DESC_WORDS - 1;
    localparam int NCTR   = 2;
    localparam int C_IN   = 0;
    localparam int C_OUT  = 1;

    state_e            state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] dptr_q;
    logic [1:0]        item_q;
    logic [DATA_W-1:0] hold_q;

    job_t   job;
    route_t route;
    span_t  cur;
    logic   fetch_go;
    logic   cap;

    logic              ctr_load  [NCTR];
    logic              ctr_step  [NCTR];
    logic [ADDR_W-1:0] ctr_laddr [NCTR];
    logic [CNT_W-1:0]  ctr_lwords[NCTR];
    logic [ADDR_W-1:0] ctr_addr  [NCTR];
    logic              ctr_last  [NCTR];

    assign fetch_go = fetch_wr && (state_q == S_IDLE);
    assign cap      = (state_q == S_DWAIT) && rd_rsp_valid;
    assign route    = route_op(job.op);

    always_comb begin
        case (item_q)
            2'd0:    cur = job.ctx;
            2'd1:    cur = job.key;
            default: cur = job.din;
        endcase
    end

    cc_job_store #(.WORDS(DESC_WORDS)) u_store (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .idx  (idx_q),
        .word (rd_rsp_data),
        .job  (job)
    );

    always_comb begin
        ctr_load[C_IN]    = (state_q == S_PSEL) && (cur.len != '0);
        ctr_step[C_IN]    = (state_q == S_IPUSH) && eu_in_ready;
        ctr_laddr[C_IN]   = cur.ptr;
        ctr_lwords[C_IN]  = word_count(cur.len);
        ctr_load[C_OUT]   = (state_q == S_OSEL);
        ctr_step[C_OUT]   = (state_q == S_OWR) && wr_req_ready;
        ctr_laddr[C_OUT]  = job.dout.ptr;
        ctr_lwords[C_OUT] = word_count(job.dout.len);
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        cc_xfer_ctr #(.AW(ADDR_W), .CW(CNT_W), .STEP(DATA_W / 8)) u_ctr (
            .clk        (clk),
            .rst        (rst),
            .load       (ctr_load[g]),
            .load_addr  (ctr_laddr[g]),
            .load_words (ctr_lwords[g]),
            .step       (ctr_step[g]),
            .addr       (ctr_addr[g]),
            .last       (ctr_last[g])
        );
    end

    cc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .clr       (fetch_go),
        .set_done  (state_q == S_FIN),
        .set_err   ((state_q == S_DECODE) && !route.known),
        .done_flag (status_done),
        .err_flag  (status_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            dptr_q  <= '0;
            item_q  <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (fetch_go) begin
                    dptr_q  <= fetch_addr;
                    idx_q   <= '0;
                    state_q <= S_DREQ;
                end
                S_DREQ: if (rd_req_ready) state_q <= S_DWAIT;
                S_DWAIT: if (rd_rsp_valid) begin
                    if (idx_q == IDX_W'(LAST_W)) begin
                        state_q <= S_DECODE;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= S_DREQ;
                    end
                end
                S_DECODE: state_q <= route.known ? S_ALLOC : S_IDLE;
                S_ALLOC: if (eu_grant) begin
                    item_q  <= '0;
                    state_q <= S_PSEL;
                end
                S_PSEL: begin
                    if (cur.len != '0) begin
                        state_q <= S_IREQ;
                    end else if (item_q == 2'(ITEMS_IN - 1)) begin
                        state_q <= S_OSEL;
                    end else begin
                        item_q <= item_q + 2'd1;
                    end
                end
                S_IREQ: if (rd_req_ready) state_q <= S_IWAIT;
                S_IWAIT: if (rd_rsp_valid) begin
                    hold_q  <= rd_rsp_data;
                    state_q <= S_IPUSH;
                end
                S_IPUSH: if (eu_in_ready) begin
                    if (!ctr_last[C_IN]) begin
                        state_q <= S_IREQ;
                    end else if (item_q == 2'(ITEMS_IN - 1)) begin
                        state_q <= S_OSEL;
                    end else begin
                        item_q  <= item_q + 2'd1;
                        state_q <= S_PSEL;
                    end
                end
                S_OSEL: state_q <= (job.dout.len == '0) ? S_REL : S_OPULL;
                S_OPULL: if (eu_out_valid) begin
                    hold_q  <= eu_out_data;
                    state_q <= S_OWR;
                end
                S_OWR: if (wr_req_ready) begin
                    state_q <= ctr_last[C_OUT] ? S_REL : S_OPULL;
                end
                S_REL: begin
                    if (job.next != '0) begin
                        dptr_q  <= job.next;
                        idx_q   <= '0;
                        state_q <= S_DREQ;
                    end else begin
                        state_q <= S_FIN;
                    end
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rd_req_valid = (state_q == S_DREQ) || (state_q == S_IREQ);
    assign rd_req_addr  = (state_q == S_DREQ)
                        ? dptr_q + ADDR_W'(idx_q) * ADDR_W'(DATA_W / 8)
                        : ctr_addr[C_IN];
    assign wr_req_valid = (state_q == S_OWR);
    assign wr_req_addr  = ctr_addr[C_OUT];
    assign wr_req_data  = hold_q;
    assign eu_req       = (state_q == S_ALLOC);
    assign eu_type      = route.unit;
    assign eu_release   = (state_q == S_REL);
    assign eu_in_valid  = (state_q == S_IPUSH);
    assign eu_in_data   = hold_q;
    assign eu_in_kind   = item_q;
    assign eu_out_ready = (state_q == S_OPULL);
    assign busy         = (state_q != S_IDLE);
    assign done         = (state_q == S_FIN);

endmodule

// File: rtl/cc_channel_checker.sv
module cc_channel_checker (
    input logic        clk,
    input logic        rst,
    input logic        fetch_wr,
    input logic [31:0] fetch_addr,
    input logic        busy,
    input logic        rd_req_valid,
    input logic        rd_req_ready,
    input logic [31:0] rd_req_addr,
    input logic        wr_req_valid,
    input logic        wr_req_ready,
    input logic [31:0] wr_req_addr,
    input logic [63:0] wr_req_data,
    input logic        eu_req,
    input logic        eu_grant,
    input logic        eu_release,
    input logic        eu_in_valid,
    input logic        eu_in_ready,
    input logic [63:0] eu_in_data,
    input logic        done,
    input logic        status_done,
    input logic        status_err
);

    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else if (eu_req && eu_grant) held_q <= 1'b1;
        else if (eu_release) held_q <= 1'b0;
    end

    AST_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && fetch_wr) |=> (busy && rd_req_valid && rd_req_addr == $past(fetch_addr))); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R12
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data))); // R12
    AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eu_in_valid && !eu_in_ready) |=> (eu_in_valid && $stable(eu_in_data))); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eu_req && !eu_grant) |=> eu_req); // R3
    AST_IN_NEEDS_UNIT: assert property (@(posedge clk) disable iff (rst)
        eu_in_valid |-> held_q); // R3
    AST_WR_NEEDS_UNIT: assert property (@(posedge clk) disable iff (rst)
        wr_req_valid |-> held_q); // R7
    AST_REL_PULSE: assert property (@(posedge clk) disable iff (rst)
        eu_release |=> !eu_release); // R8
    AST_REL_HELD: assert property (@(posedge clk) disable iff (rst)
        eu_release |-> held_q); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |=> status_done); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        status_err |-> (!eu_req && !done && !eu_in_valid)); // R11

endmodule

bind cc_channel cc_channel_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_wr     (fetch_wr),
    .fetch_addr   (fetch_addr),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .wr_req_valid (wr_req_valid),
    .wr_req_ready (wr_req_ready),
    .wr_req_addr  (wr_req_addr),
    .wr_req_data  (wr_req_data),
    .eu_req       (eu_req),
    .eu_grant     (eu_grant),
    .eu_release   (eu_release),
    .eu_in_valid  (eu_in_valid),
    .eu_in_ready  (eu_in_ready),
    .eu_in_data   (eu_in_data),
    .done         (done),
    .status_done  (status_done),
    .status_err   (status_err)
);

// File: tb/cc_channel_bench.sv
module cc_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam logic [63:0] OUT_BASE = 64'hC0DE_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_wr = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        rd_req_valid, rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        wr_req_valid, wr_req_ready = 1'b0;
    logic [31:0] wr_req_addr;
    logic [63:0] wr_req_data;
    logic        eu_req, eu_grant = 1'b0, eu_release;
    logic [2:0]  eu_type;
    logic        eu_in_valid, eu_in_ready = 1'b0;
    logic [63:0] eu_in_data;
    logic [1:0]  eu_in_kind;
    logic        eu_out_valid = 1'b0, eu_out_ready;
    logic [63:0] eu_out_data = '0;
    logic        busy, done, status_done, status_err;

    cc_channel u_cc_channel (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [63:0] mem [int unsigned];
    logic [31:0] exp_rd [$];
    logic [65:0] exp_in [$];
    logic [95:0] exp_wr [$];
    logic [2:0]  exp_unit [$];
    int          exp_rel [$];
    int  wr_gen = 0, wr_seen = 0, out_sent = 0;
    int  grants = 0, rels = 0, dones = 0;
    bit  held = 0, rsp_pending = 0;
    int  rsp_cnt = 0, gnt_wait = 2;
    logic [31:0] rsp_addr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [63:0] pat(input logic [31:0] a);
        return {a ^ 32'h5A5A_0F0F, ~a};
    endfunction

    function automatic logic [63:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : pat(a);
    endfunction

    function automatic int nwords(input int len);
        return (len + 7) / 8;
    endfunction

    // Builds a descriptor in memory and appends the traffic it must cause (R2 R4 R5 R7)
    task automatic add_desc(input logic [31:0] base, input logic [7:0] op, input int unit,
                            input int cl, input logic [31:0] cp, input int kl, input logic [31:0] kp,
                            input int dl, input logic [31:0] dp, input int ol, input logic [31:0] op_ptr,
                            input logic [31:0] nxt);
        int lens[3];
        logic [31:0] ptrs[3];
        mem[base]      = {op, 56'h0};
        mem[base + 8]  = {32'(cl), cp};
        mem[base + 16] = {32'(kl), kp};
        mem[base + 24] = {32'(dl), dp};
        mem[base + 32] = {32'(ol), op_ptr};
        mem[base + 40] = {32'hFFFF_FFFF, nxt};
        for (int i = 0; i < 6; i++) exp_rd.push_back(base + 32'(8 * i));
        if (unit == 0) return;
        exp_unit.push_back(3'(unit));
        lens[0] = cl; lens[1] = kl; lens[2] = dl;
        ptrs[0] = cp; ptrs[1] = kp; ptrs[2] = dp;
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < nwords(lens[p]); k++) begin
                exp_rd.push_back(ptrs[p] + 32'(8 * k));
                exp_in.push_back({2'(p), pat(ptrs[p] + 32'(8 * k))});
            end
        end
        for (int k = 0; k < nwords(ol); k++) begin
            exp_wr.push_back({op_ptr + 32'(8 * k), OUT_BASE + 64'(wr_gen)});
            wr_gen++;
        end
        exp_rel.push_back(wr_gen);
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        fetch_wr = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        fetch_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, "R9", "channel returns to idle", busy, 0);
    endtask

    // Memory, controller and execution unit model, compared every clock
    initial begin
        forever begin
            @(negedge clk);
            if (rst) continue;
            cyc++;
            if (cyc > WD_LIMIT) begin
                check(0, "WD", "watchdog expired", cyc, WD_LIMIT);
                finish_run();
            end
            rd_req_ready = (cyc % 3) != 0;
            wr_req_ready = (cyc % 4) != 1;
            eu_in_ready  = (cyc % 5) != 2;
            eu_out_valid = (cyc % 3) != 1;
            eu_out_data  = OUT_BASE + 64'(out_sent);
            rd_rsp_valid = 1'b0;
            if (rsp_pending) begin
                if (rsp_cnt > 0) rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem_rd(rsp_addr);
                    rsp_pending  = 0;
                end
            end
            eu_grant = 1'b0;
            if (eu_req) begin
                if (gnt_wait == 0) eu_grant = 1'b1;
                else gnt_wait--;
            end
            #1;
            if (rd_req_valid && rd_req_ready) begin
                check(exp_rd.size() > 0 && exp_rd[0] == rd_req_addr, "R2",
                      "read address order (R4 R5 R9)", rd_req_addr,
                      exp_rd.size() > 0 ? exp_rd[0] : 32'hDEAD);
                if (exp_rd.size() > 0) void'(exp_rd.pop_front());
                rsp_pending = 1;
                rsp_cnt = 1;
                rsp_addr = rd_req_addr;
            end
            if (eu_req && eu_grant) begin
                check(exp_unit.size() > 0 && exp_unit[0] == eu_type, "R3", "unit type",
                      eu_type, exp_unit.size() > 0 ? exp_unit[0] : 3'h7);
                if (exp_unit.size() > 0) void'(exp_unit.pop_front());
                held = 1;
                grants++;
                gnt_wait = 2;
            end
            if (eu_in_valid && eu_in_ready) begin
                check(held, "R3", "unit input only after grant", held, 1);
                check(exp_in.size() > 0 && exp_in[0] == {eu_in_kind, eu_in_data}, "R4",
                      "unit input kind and data (R6)", {eu_in_kind, eu_in_data},
                      exp_in.size() > 0 ? exp_in[0] : '1);
                if (exp_in.size() > 0) void'(exp_in.pop_front());
            end
            if (eu_out_valid && eu_out_ready) out_sent++;
            if (wr_req_valid && wr_req_ready) begin
                check(held, "R3", "memory write only while unit held", held, 1);
                check(exp_wr.size() > 0 && exp_wr[0] == {wr_req_addr, wr_req_data}, "R7",
                      "write address and data", {wr_req_addr, wr_req_data},
                      exp_wr.size() > 0 ? exp_wr[0] : '1);
                if (exp_wr.size() > 0) void'(exp_wr.pop_front());
                wr_seen++;
            end
            if (eu_release) begin
                check(held && exp_rel.size() > 0 && exp_rel[0] == wr_seen, "R8",
                      "release after last write", wr_seen,
                      exp_rel.size() > 0 ? exp_rel[0] : -1);
                if (exp_rel.size() > 0) void'(exp_rel.pop_front());
                held = 0;
                rels++;
            end
            if (done) dones++;
        end
    end

    initial begin
        int g0, d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !status_done && !status_err, "R10", "reset status",
              {busy, done, status_done, status_err}, 0);
        check(!rd_req_valid && !wr_req_valid && !eu_req && !eu_in_valid, "R1", "reset requests idle",
              {rd_req_valid, wr_req_valid, eu_req, eu_in_valid}, 0);

        // Test 1: single descriptor, odd data length, fetch write ignored while busy
        add_desc(32'h1000, 8'h22, 2, 8, 32'h2000, 16, 32'h2100, 20, 32'h2200, 24, 32'h3000, 32'h0);
        kick(32'h1000);
        check(busy, "R1", "busy after fetch write", busy, 1);
        repeat (5) @(negedge clk);
        kick(32'h1800);
        wait_idle();
        @(negedge clk);
        check(dones == 1 && status_done, "R10", "single done and sticky flag", {dones, status_done}, {32'd1, 1'b1});
        check(exp_rd.size() == 0 && exp_in.size() == 0 && exp_wr.size() == 0, "R1",
              "all traffic seen, ignored fetch caused none", exp_rd.size() + exp_in.size() + exp_wr.size(), 0);

        // Test 2: chain of three, skips, long data item beyond 512 bytes
        add_desc(32'h4000, 8'h11, 1, 0, 32'h0, 8, 32'h5000, 600, 32'h6000, 600, 32'h8000, 32'h4100);
        add_desc(32'h4100, 8'h44, 4, 16, 32'h5100, 0, 32'h0, 8, 32'h5200, 0, 32'h0, 32'h4200);
        add_desc(32'h4200, 8'h33, 3, 8, 32'h5300, 8, 32'h5400, 8, 32'h5500, 8, 32'h5600, 32'h0);
        d0 = dones;
        kick(32'h4000);
        check(!status_done, "R10", "done flag cleared by new fetch", status_done, 0);
        wait_idle();
        @(negedge clk);
        check(dones == d0 + 1, "R9", "one done for whole chain", dones, d0 + 1);
        check(rels == 4 && grants == 4, "R8", "one release per descriptor", {rels, grants}, {32'd4, 32'd4});
        check(exp_rd.size() == 0 && exp_in.size() == 0, "R6", "long item fully streamed (R5)",
              exp_rd.size() + exp_in.size(), 0);
        check(exp_wr.size() == 0, "R7", "all output words written", exp_wr.size(), 0);

        // Test 3: unknown operation code
        add_desc(32'h9000, 8'h7E, 0, 8, 32'h5000, 8, 32'h5000, 8, 32'h5000, 8, 32'h5000, 32'h0);
        g0 = grants;
        d0 = dones;
        kick(32'h9000);
        wait_idle();
        @(negedge clk);
        check(status_err && !status_done, "R11", "error flag set", {status_err, status_done}, 2'b10);
        check(grants == g0 && dones == d0, "R11", "no unit and no done", {grants, dones}, {g0, d0});
        check(exp_rd.size() == 0, "R2", "six descriptor words read", exp_rd.size(), 0);

        // Test 4: recovery after error
        add_desc(32'h9100, 8'h33, 3, 0, 32'h0, 8, 32'hA000, 8, 32'hA100, 16, 32'hB000, 32'h0);
        kick(32'h9100);
        check(!status_err, "R11", "error cleared by next fetch", status_err, 0);
        wait_idle();
        @(negedge clk);
        check(dones == d0 + 1 && status_done, "R10", "done after recovery", dones, d0 + 1);
        check(exp_rd.size() == 0 && exp_in.size() == 0 && exp_wr.size() == 0 && exp_rel.size() == 0,
              "R7", "no leftover traffic", exp_rd.size() + exp_in.size() + exp_wr.size() + exp_rel.size(), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule